// File: doc/BRIEF.md
# Timer Update-Event and Shadow-Register Controller

This block is the counting slice of a general-purpose timer. It holds an up/down counter, a clock prescaler and three register pairs: one for the period, one for the prescaler divide value and one for a compare value. Software writes only the preload half of each pair. The active half, which the counter and prescaler use, takes the preload value only when an update event happens. An update event comes from a counter wrap (overflow or underflow), from a software update strobe, or from a reset request sent by an external slave-mode controller.

Two level controls shape the update path. The source filter limits update reporting to counter wraps only. The update inhibit suppresses the update event entirely, although a software strobe or an external reset still reinitialises the counter and the prescaler. A reported update sets a sticky interrupt flag and pulses a one-cycle DMA request. Each of these is gated by its own enable. The counter advances only while its run bit is set. Software writes that bit, and an external trigger pulse can also set it.

Top module: `tmr_update_ctrl`

## Requirements
- R1: After reset the count is 0, the flag and DMA request are 0, the active period is all ones, and the active prescaler and compare values are 0.
- R2: A preload write does not change the matching active register. The active register takes the preload value on the clock edge of the next update event.
- R3: When counting up, the count advances by one on every (active prescaler + 1)-th clock while running. After the active period value it wraps to 0, and that wrap is an update source.
- R4: When counting down (dir_down = 1), the count steps down by one. After 0 it reloads to the active period value, and that underflow is an update source.
- R5: With the run bit at 0 the count holds. An ext_trig pulse sets the run bit, and an en_wr write sets it to en_wdata, with ext_trig taking priority.
- R6: With upd_src_sel = 0, a wrap, a sw_update strobe and an ext_reset pulse each set the flag and pulse the DMA request on the next edge.
- R7: With upd_src_sel = 1, only a counter wrap sets the flag or pulses the DMA request. A sw_update strobe still loads the active registers.
- R8: With upd_dis = 1, no update event occurs: active registers keep their values and neither the flag nor the DMA request is raised.
- R9: The flag stays at 1 until flag_clr. It sets only when irq_en = 1. dma_req is high for one cycle per reported update and only when dma_en = 1.
- R10: A sw_update or ext_reset pulse clears the prescaler and loads the count with 0 when counting up, or with the period when counting down. This happens even with upd_dis = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Strobe writing the run bit |
| en_wdata | input | 1 | Value written to the run bit |
| ext_trig | input | 1 | Trigger pulse that sets the run bit |
| ext_reset | input | 1 | Slave-mode reset pulse (reinit and update source) |
| sw_update | input | 1 | Software update strobe, one cycle |
| dir_down | input | 1 | 1 counts down, 0 counts up |
| upd_src_sel | input | 1 | 1 reports counter wraps only |
| upd_dis | input | 1 | 1 suppresses update events |
| irq_en | input | 1 | Enables setting the update flag |
| dma_en | input | 1 | Enables the DMA request strobe |
| flag_clr | input | 1 | Clears the update flag |
| period_wr | input | 1 | Period preload write strobe |
| period_wdata | input | CNT_W | Period preload data |
| psc_wr | input | 1 | Prescaler preload write strobe |
| psc_wdata | input | PSC_W | Prescaler preload data |
| cmp_wr | input | 1 | Compare preload write strobe |
| cmp_wdata | input | CNT_W | Compare preload data |
| count | output | CNT_W | Counter value |
| upd_flag | output | 1 | Sticky update interrupt flag |
| dma_req | output | 1 | One-cycle DMA request |
| active_period | output | CNT_W | Active period value |
| active_psc | output | PSC_W | Active prescaler value |
| active_cmp | output | CNT_W | Active compare value |

## Verification
The bench counts clocks through a divide-by-three prescaler to the exact edge of an up wrap and a down reload. A design with an off-by-one in the divider or the wrap compare would show the wrong count on a named edge. It sends software strobes and slave resets with the source filter on. A design that did not filter sources would raise the flag there, while one that also blocked the shadow load would leave the compare value stale. With updates inhibited it strobes while a new period waits in preload. A design that tied reinitialisation to the update event would leave the count running, and one that ignored the inhibit would load the new period. It also checks that the flag and DMA enables act independently and that the DMA request drops after one cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_WRAP = 2'd1,
    UPD_SW   = 2'd2,
    UPD_EXT  = 2'd3
  } upd_cause_e;

  // Wrap is ranked first so the filtered mode sees it whatever else coincides.
  function automatic upd_cause_e pick_cause(input logic wrap, input logic sw, input logic ext);
    if (wrap)     return UPD_WRAP;
    else if (sw)  return UPD_SW;
    else if (ext) return UPD_EXT;
    else          return UPD_NONE;
  endfunction

  function automatic logic cause_reported(input logic wrap_only, input upd_cause_e cause);
    if (wrap_only) return cause == UPD_WRAP;
    else           return cause != UPD_NONE;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [PSC_W-1:0] limit,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = run && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (clear)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else if (run)    div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             down,
  input  logic             reinit,
  input  logic [CNT_W-1:0] period_cur,
  input  logic [CNT_W-1:0] period_next,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  function automatic logic at_end(input logic [CNT_W-1:0] c, input logic dn,
                                  input logic [CNT_W-1:0] per);
    return dn ? (c == '0) : (c == per);
  endfunction

  function automatic logic [CNT_W-1:0] start_value(input logic dn,
                                                   input logic [CNT_W-1:0] per);
    return dn ? per : '0;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic dn);
    return dn ? c - 1'b1 : c + 1'b1;
  endfunction

  assign wrap = tick && at_end(count, down, period_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (reinit)  count <= start_value(down, period_next);
    else if (wrap)    count <= start_value(down, period_next);
    else if (tick)    count <= step(count, down);
  end
endmodule

// File: rtl/tmr_preload_reg.sv
module tmr_preload_reg #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] active,
  output logic [W-1:0] next_val
);
  logic [W-1:0] pre_q;

  assign next_val = load ? pre_q : active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= RST_VAL;
      active <= RST_VAL;
    end else begin
      if (wr) pre_q <= wdata;
      active <= next_val;
    end
  end
endmodule

// File: rtl/tmr_update_ctrl.sv
module tmr_update_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             ext_trig,
  input  logic             ext_reset,
  input  logic             sw_update,
  input  logic             dir_down,
  input  logic             upd_src_sel,
  input  logic             upd_dis,
  input  logic             irq_en,
  input  logic             dma_en,
  input  logic             flag_clr,
  input  logic             period_wr,
  input  logic [CNT_W-1:0] period_wdata,
  input  logic             psc_wr,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic             upd_flag,
  output logic             dma_req,
  output logic [CNT_W-1:0] active_period,
  output logic [PSC_W-1:0] active_psc,
  output logic [CNT_W-1:0] active_cmp
);
  localparam logic [CNT_W-1:0] PERIOD_RST = {CNT_W{1'b1}};

  logic             en_q;
  logic             tick;
  logic             wrap_evt;
  logic             reinit;
  logic             upd_evt;
  logic             upd_report;
  upd_cause_e       cause;
  logic [CNT_W-1:0] period_next;
  logic [PSC_W-1:0] psc_next;
  logic [CNT_W-1:0] cmp_next;

  assign reinit     = sw_update | ext_reset;
  assign cause      = pick_cause(wrap_evt, sw_update, ext_reset);
  assign upd_evt    = !upd_dis && (cause != UPD_NONE);
  assign upd_report = upd_evt && cause_reported(upd_src_sel, cause);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (ext_trig) en_q <= 1'b1;
    else if (en_wr)    en_q <= en_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_flag <= 1'b0;
      dma_req  <= 1'b0;
    end else begin
      if (upd_report && irq_en) upd_flag <= 1'b1;
      else if (flag_clr)        upd_flag <= 1'b0;
      dma_req <= upd_report && dma_en;
    end
  end

  tmr_preload_reg #(.W(CNT_W), .RST_VAL(PERIOD_RST)) u_period (
    .clk(clk), .rst_n(rst_n), .wr(period_wr), .wdata(period_wdata),
    .load(upd_evt), .active(active_period), .next_val(period_next)
  );

  tmr_preload_reg #(.W(PSC_W), .RST_VAL('0)) u_psc (
    .clk(clk), .rst_n(rst_n), .wr(psc_wr), .wdata(psc_wdata),
    .load(upd_evt), .active(active_psc), .next_val(psc_next)
  );

  tmr_preload_reg #(.W(CNT_W), .RST_VAL('0)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
    .load(upd_evt), .active(active_cmp), .next_val(cmp_next)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_q), .clear(reinit),
    .limit(active_psc), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .down(dir_down), .reinit(reinit),
    .period_cur(active_period), .period_next(period_next),
    .count(count), .wrap(wrap_evt)
  );
endmodule

// File: rtl/tmr_update_chk.sv
module tmr_update_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             wrap_evt,
  input logic             reinit,
  input logic             sw_update,
  input logic             dir_down,
  input logic             upd_src_sel,
  input logic             upd_dis,
  input logic             dma_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic             upd_flag,
  input logic             dma_req,
  input logic [CNT_W-1:0] active_period,
  input logic [PSC_W-1:0] active_psc,
  input logic [CNT_W-1:0] active_cmp
);
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && !dir_down && !reinit |=> count == '0);

  p_down_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && dir_down && !reinit |=> count == active_period);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !reinit |=> $stable(count));

  p_any_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_src_sel && !upd_dis && sw_update && dma_en |=> dma_req);

  p_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_src_sel && !wrap_evt |=> !dma_req);

  p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_dis |=> $stable(active_period) && $stable(active_psc) && $stable(active_cmp));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flag && !flag_clr |=> upd_flag);

  p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dma_req);

  p_reinit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_update && !dir_down |=> count == '0);
endmodule

bind tmr_update_ctrl tmr_update_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .wrap_evt(wrap_evt), .reinit(reinit),
  .sw_update(sw_update), .dir_down(dir_down), .upd_src_sel(upd_src_sel),
  .upd_dis(upd_dis), .dma_en(dma_en), .flag_clr(flag_clr), .count(count),
  .upd_flag(upd_flag), .dma_req(dma_req), .active_period(active_period),
  .active_psc(active_psc), .active_cmp(active_cmp)
);

// File: tb/tb_tmr_update_ctrl.sv
module tb_tmr_update_ctrl;
  localparam int CW = 16;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 0, en_wdata = 0, ext_trig = 0, ext_reset = 0, sw_update = 0;
  logic dir_down = 0, upd_src_sel = 0, upd_dis = 0, irq_en = 0, dma_en = 0, flag_clr = 0;
  logic period_wr = 0, psc_wr = 0, cmp_wr = 0;
  logic [CW-1:0] period_wdata = '0, cmp_wdata = '0;
  logic [PW-1:0] psc_wdata = '0;
  logic [CW-1:0] count, active_period, active_cmp;
  logic [PW-1:0] active_psc;
  logic upd_flag, dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tmr_update_ctrl #(.CNT_W(CW), .PSC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .ext_trig(ext_trig),
    .ext_reset(ext_reset), .sw_update(sw_update), .dir_down(dir_down),
    .upd_src_sel(upd_src_sel), .upd_dis(upd_dis), .irq_en(irq_en), .dma_en(dma_en),
    .flag_clr(flag_clr), .period_wr(period_wr), .period_wdata(period_wdata),
    .psc_wr(psc_wr), .psc_wdata(psc_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .count(count), .upd_flag(upd_flag), .dma_req(dma_req),
    .active_period(active_period), .active_psc(active_psc), .active_cmp(active_cmp)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_sw();
    sw_update = 1; step(); sw_update = 0;
  endtask

  task automatic pulse_ext();
    ext_reset = 1; step(); ext_reset = 0;
  endtask

  task automatic set_run(input logic v);
    en_wr = 1; en_wdata = v; step(); en_wr = 0;
  endtask

  task automatic clear_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 flag", upd_flag, 0);
    chk("R1 dma", dma_req, 0);
    chk("R1 period", active_period, 16'hFFFF);
    chk("R1 psc", active_psc, 0);
    chk("R1 cmp", active_cmp, 0);
  endtask

  task automatic t_preload();
    irq_en = 1; dma_en = 1;
    period_wr = 1; period_wdata = 5; psc_wr = 1; psc_wdata = 2; cmp_wr = 1; cmp_wdata = 3;
    step();
    period_wr = 0; psc_wr = 0; cmp_wr = 0;
    chk("R2 period held", active_period, 16'hFFFF);
    chk("R2 psc held", active_psc, 0);
    pulse_sw();
    chk("R2 period load", active_period, 5);
    chk("R2 psc load", active_psc, 2);
    chk("R2 cmp load", active_cmp, 3);
    chk("R6 flag on sw", upd_flag, 1);
    chk("R9 dma pulse", dma_req, 1);
    step();
    chk("R9 dma one cycle", dma_req, 0);
    chk("R9 flag sticky", upd_flag, 1);
    clear_flag();
    chk("R9 flag cleared", upd_flag, 0);
  endtask

  task automatic t_upcount();
    step(); step();
    chk("R5 hold stopped", count, 0);
    set_run(1);
    for (int n = 1; n <= 18; n++) begin
      step();
      chk("R3 up count", count, (n / 3) % 6);
      chk("R3 flag", upd_flag, n >= 18 ? 1 : 0);
    end
    chk("R3 wrap dma", dma_req, 1);
    step();
    chk("R9 dma drop", dma_req, 0);
    set_run(0);
    clear_flag();
  endtask

  task automatic t_filter();
    upd_src_sel = 1;
    cmp_wr = 1; cmp_wdata = 7; step(); cmp_wr = 0;
    pulse_sw();
    chk("R7 sw no flag", upd_flag, 0);
    chk("R7 sw no dma", dma_req, 0);
    chk("R7 sw still loads", active_cmp, 7);
    pulse_ext();
    chk("R7 ext no flag", upd_flag, 0);
    upd_src_sel = 0;
    pulse_ext();
    chk("R6 ext flag", upd_flag, 1);
    chk("R6 ext dma", dma_req, 1);
    clear_flag();
    upd_src_sel = 1;
    psc_wr = 1; psc_wdata = 0; step(); psc_wr = 0;
    pulse_sw();
    chk("R7 psc loaded", active_psc, 0);
    set_run(1);
    for (int k = 1; k <= 6; k++) step();
    chk("R7 wrap count", count, 0);
    chk("R7 wrap flag", upd_flag, 1);
    chk("R7 wrap dma", dma_req, 1);
    set_run(0);
    clear_flag();
    upd_src_sel = 0;
    chk("R5 held after stop", count, 1);
  endtask

  task automatic t_inhibit();
    upd_dis = 1;
    period_wr = 1; period_wdata = 9; step(); period_wr = 0;
    pulse_sw();
    chk("R10 sw reinit", count, 0);
    chk("R8 period kept", active_period, 5);
    chk("R8 no flag", upd_flag, 0);
    chk("R8 no dma", dma_req, 0);
    set_run(1);
    step(); step();
    chk("R3 running", count, 2);
    pulse_ext();
    chk("R10 ext reinit", count, 0);
    chk("R8 ext no load", active_period, 5);
    chk("R8 ext no flag", upd_flag, 0);
    set_run(0);
    upd_dis = 0;
    pulse_sw();
    chk("R2 pending load", active_period, 9);
    period_wr = 1; period_wdata = 5; step(); period_wr = 0;
    pulse_sw();
    clear_flag();
  endtask

  task automatic t_down();
    dir_down = 1;
    pulse_sw();
    chk("R10 down reinit", count, 5);
    clear_flag();
    set_run(1);
    for (int k = 1; k <= 6; k++) begin
      step();
      chk("R4 down count", count, k < 6 ? 5 - k : 5);
      chk("R4 underflow flag", upd_flag, k == 6 ? 1 : 0);
    end
    set_run(0);
    dir_down = 0;
    clear_flag();
  endtask

  task automatic t_trigger();
    pulse_sw();
    clear_flag();
    chk("R5 start zero", count, 0);
    ext_trig = 1; step(); ext_trig = 0;
    chk("R5 trig edge", count, 0);
    step();
    chk("R5 trig runs", count, 1);
    set_run(0);
  endtask

  task automatic t_gating();
    irq_en = 0; dma_en = 1;
    pulse_sw();
    chk("R9 irq gated flag", upd_flag, 0);
    chk("R9 dma alone", dma_req, 1);
    irq_en = 1; dma_en = 0;
    pulse_sw();
    chk("R9 flag alone", upd_flag, 1);
    chk("R9 dma gated", dma_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_preload();
    t_upcount();
    t_filter();
    t_inhibit();
    t_down();
    t_trigger();
    t_gating();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule